// File: doc/BRIEF.md
# Debug Port Pin Sharing Controller

This block arbitrates five shared package pins between a combined JTAG / serial-wire debug port and the general-purpose I/O controller. Software writes a 3-bit mode field in a 32-bit register over a simple request/ready bus. The field selects how many of the pins the debug port keeps. The rest go to GPIO, so a small debug connection frees as many I/Os as possible.

Each pin has an ownership select. While a pin is handed to GPIO, the debug core's matching input is held at a safe constant, so the debug logic never sees a floating or glitching level. That matters most for the clock pin, which drives flip-flops directly. Release and re-acquisition are each sequenced over two cycles.

A write may take one wait cycle when the upstream bridge reports a full write buffer. Reads always complete at once. While a pin is owned by debug, the block also supplies its default pull setting.

Top module: `dbg_pin_share`

## Requirements
- R1: After reset the mode field reads 000. All five selects are 1 (debug owns), no core input is forced, and the error flag is 0.
- R2: The pin vector order is bit0 TMS/SWDIO, bit1 TCK/SWCLK, bit2 TDI, bit3 TDO, bit4 nTRST. The field in bits 26:24 sets debug ownership as follows: mode 000 gives 11111, 001 gives 01111, 010 gives 00011 and 100 gives 00000. The field reads back in bits 26:24.
- R3: A write whose field has more than one bit set leaves the mode unchanged and sets the error flag. The flag stays set until the next accepted write with a legal field, which clears it.
- R4: When a pin loses debug ownership, its force output rises one cycle after the mode register changes. Its select falls in the cycle after that.
- R5: The core input of a forced pin carries its safe constant: 1 for TMS, TDI and nTRST, and 0 for TCK and TDO. The core input of an unforced pin follows the pad input.
- R6: When a pin returns to debug, its select rises first and its force output clears one cycle later.
- R7: A read completes in the cycle it is requested, with no wait state.
- R8: A write completes after exactly one wait cycle when the write-buffer-full input is high, and with none when it is low.
- R9: A debug-owned pin gets a pull-up on TMS, TDI and nTRST, a pull-down on TCK, and no pull on TDO. A GPIO-owned pin gets neither pull.
- R10: Register bits outside 26:24 read as zero, and written values in them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| req_i | input | 1 | Bus transfer request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 32 | Write data |
| wbuf_full_i | input | 1 | Upstream write buffer full; write takes a wait cycle |
| ready_o | output | 1 | Transfer completes at the edge where req_i and ready_o are high |
| rdata_o | output | 32 | Register contents |
| cfg_err_o | output | 1 | Last write carried an illegal field |
| pad_in_i | input | 5 | Pad input levels |
| core_in_o | output | 5 | Levels presented to the debug core |
| pin_dbg_sel_o | output | 5 | Per-pin owner select, 1 = debug, 0 = GPIO |
| core_force_o | output | 5 | Per-pin core input forced to safe constant |
| pull_up_o | output | 5 | Default pull-up enable |
| pull_dn_o | output | 5 | Default pull-down enable |

## Verification
A corrupted mode register shows up on the read data at once. It reaches the select and force vectors within two cycles, as a pin handed over that should not be, or kept when it should go. A sequencer stuck in its transitional state shows as a pin whose select and force are both high for longer than one cycle. An inverted order shows as the select moving in the same cycle as, or before, the force. A wrong wait-state flag is visible in the very cycle of the transfer, as a missing or extra low on ready.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int unsigned NPINS     = 5;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned FIELD_LSB = 24;
  localparam int unsigned FIELD_W   = 3;

  localparam int unsigned PIN_TMS  = 0;
  localparam int unsigned PIN_TCK  = 1;
  localparam int unsigned PIN_TDI  = 2;
  localparam int unsigned PIN_TDO  = 3;
  localparam int unsigned PIN_NRST = 4;

  // constant levels presented to the core while a pin is released
  localparam logic [NPINS-1:0] SAFE_LVL = NPINS'(5'b10101);
  localparam logic [NPINS-1:0] PU_MASK  = NPINS'(5'b10101);
  localparam logic [NPINS-1:0] PD_MASK  = NPINS'(5'b00010);

  typedef enum logic [FIELD_W-1:0] {
    MODE_FULL    = 3'b000,
    MODE_NO_RST  = 3'b001,
    MODE_SW_ONLY = 3'b010,
    MODE_NONE    = 3'b100
  } mode_e;

  function automatic logic [NPINS-1:0] own_mask(input logic [FIELD_W-1:0] m);
    case (m)
      MODE_FULL:    own_mask = '1;
      MODE_NO_RST:  own_mask = NPINS'(5'b01111);
      MODE_SW_ONLY: own_mask = NPINS'(5'b00011);
      default:      own_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/dps_regif.sv
module dps_regif
  import dps_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned LSB = FIELD_LSB,
  parameter int unsigned FW  = FIELD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wbuf_full_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic [FW-1:0] mode_o,
  output logic          err_o
);
  logic [FW-1:0] mode_q;
  logic          wait_q, err_q;
  logic          wr_req, stall, done, legal;
  logic [FW-1:0] field;

  assign wr_req  = req_i & we_i;
  assign stall   = wr_req & wbuf_full_i & ~wait_q;
  assign ready_o = ~stall;
  assign done    = wr_req & ready_o;
  assign field   = wdata_i[LSB +: FW];
  assign legal   = ($countones(field) <= 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      wait_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      wait_q <= stall;
      if (done) begin
        err_q <= ~legal;
        if (legal) mode_q <= field;
      end
    end
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[LSB +: FW] = mode_q;
  end

  assign mode_o = mode_q;
  assign err_o  = err_q;

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[DW-1:LSB+FW], wdata_i[LSB-1:0]};
endmodule

// File: rtl/dps_seq.sv
module dps_seq
  import dps_pkg::*;
#(
  parameter int unsigned N = NPINS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] want_i,
  output logic [N-1:0] sel_o,
  output logic [N-1:0] force_o
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic sel_q, force_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_q   <= 1'b1;
        force_q <= 1'b0;
      end else begin
        // release: force first, select next; acquire: select first, unforce next
        force_q <= ~want_i[i] | ~sel_q;
        sel_q   <= want_i[i] | ~force_q;
      end
    end
    assign sel_o[i]   = sel_q;
    assign force_o[i] = force_q;
  end
endmodule

// File: rtl/dps_padmux.sv
module dps_padmux
  import dps_pkg::*;
#(
  parameter int unsigned N = NPINS
) (
  input  logic [N-1:0] sel_i,
  input  logic [N-1:0] force_i,
  input  logic [N-1:0] pad_in_i,
  output logic [N-1:0] core_in_o,
  output logic [N-1:0] pull_up_o,
  output logic [N-1:0] pull_dn_o
);
  for (genvar i = 0; i < N; i++) begin : g_mux
    assign core_in_o[i] = force_i[i] ? SAFE_LVL[i] : pad_in_i[i];
    assign pull_up_o[i] = sel_i[i] & PU_MASK[i];
    assign pull_dn_o[i] = sel_i[i] & PD_MASK[i];
  end
endmodule

// File: rtl/dbg_pin_share.sv
module dbg_pin_share
  import dps_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wbuf_full_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cfg_err_o,
  input  logic [NPINS-1:0]  pad_in_i,
  output logic [NPINS-1:0]  core_in_o,
  output logic [NPINS-1:0]  pin_dbg_sel_o,
  output logic [NPINS-1:0]  core_force_o,
  output logic [NPINS-1:0]  pull_up_o,
  output logic [NPINS-1:0]  pull_dn_o
);
  logic [FIELD_W-1:0] mode;
  logic [NPINS-1:0]   want;

  dps_regif #(.DW(DATA_W), .LSB(FIELD_LSB), .FW(FIELD_W)) i_regif (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .wdata_i     (wdata_i),
    .wbuf_full_i (wbuf_full_i),
    .ready_o     (ready_o),
    .rdata_o     (rdata_o),
    .mode_o      (mode),
    .err_o       (cfg_err_o)
  );

  assign want = own_mask(mode);

  dps_seq #(.N(NPINS)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .want_i  (want),
    .sel_o   (pin_dbg_sel_o),
    .force_o (core_force_o)
  );

  dps_padmux #(.N(NPINS)) i_padmux (
    .sel_i     (pin_dbg_sel_o),
    .force_i   (core_force_o),
    .pad_in_i  (pad_in_i),
    .core_in_o (core_in_o),
    .pull_up_o (pull_up_o),
    .pull_dn_o (pull_dn_o)
  );
endmodule

// File: rtl/dbg_pin_share_chk.sv
module dbg_pin_share_chk
  import dps_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              wbuf_full_i,
  input logic              ready_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              cfg_err_o,
  input logic [NPINS-1:0]  pin_dbg_sel_o,
  input logic [NPINS-1:0]  core_force_o,
  input logic [NPINS-1:0]  pull_up_o,
  input logic [NPINS-1:0]  pull_dn_o
);
  // R2
  mode_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rdata_o[FIELD_LSB +: FIELD_W]));

  // R3
  bad_write_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && ready_o && ($countones(wdata_i[FIELD_LSB +: FIELD_W]) > 1))
    |=> ($stable(rdata_o) && cfg_err_o));

  // R7
  read_no_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |-> ready_o);

  // R8
  write_one_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && wbuf_full_i && !ready_o) |=> ready_o);

  // R10
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[DATA_W-1:FIELD_LSB+FIELD_W] == '0) && (rdata_o[FIELD_LSB-1:0] == '0));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin_chk
    // R4
    release_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pin_dbg_sel_o[i]) |-> $past(core_force_o[i]));
    // R6
    acquire_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(core_force_o[i]) |-> ($past(pin_dbg_sel_o[i]) && pin_dbg_sel_o[i]));
    // R4
    gpio_forced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pin_dbg_sel_o[i] |-> core_force_o[i]);
    // R9
    pull_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(pull_up_o[i] && pull_dn_o[i]));
  end
endmodule

bind dbg_pin_share dbg_pin_share_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .we_i          (we_i),
  .wdata_i       (wdata_i),
  .wbuf_full_i   (wbuf_full_i),
  .ready_o       (ready_o),
  .rdata_o       (rdata_o),
  .cfg_err_o     (cfg_err_o),
  .pin_dbg_sel_o (pin_dbg_sel_o),
  .core_force_o  (core_force_o),
  .pull_up_o     (pull_up_o),
  .pull_dn_o     (pull_dn_o)
);

// File: tb/test_dbg_pin_share.sv
module test_dbg_pin_share;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0, full = 0;
  logic [31:0] wdata = 0;
  logic [4:0]  pad = 0;
  logic        ready, err;
  logic [31:0] rdata;
  logic [4:0]  core_in, sel, frc, pu, pd;

  int checks = 0, errors = 0;
  bit running = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_pin_share i_dbg_pin_share (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .wdata_i(wdata),
    .wbuf_full_i(full), .ready_o(ready), .rdata_o(rdata), .cfg_err_o(err),
    .pad_in_i(pad), .core_in_o(core_in), .pin_dbg_sel_o(sel),
    .core_force_o(frc), .pull_up_o(pu), .pull_dn_o(pd)
  );

  // reference model
  int  m_mode;
  bit  m_wait, m_err;
  bit  m_sel[5], m_frc[5];

  function automatic bit owns(int mode, int p);
    case (mode)
      0: return 1;
      1: return p != 4;
      2: return p < 2;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_ready();
    return !(req && we && full && !m_wait);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_wait = 0; m_err = 0;
      for (int p = 0; p < 5; p++) begin m_sel[p] = 1; m_frc[p] = 0; end
    end else begin
      bit rdy;
      rdy = exp_ready();
      for (int p = 0; p < 5; p++) begin
        bit w;
        w = owns(m_mode, p);
        if (w && !m_sel[p]) m_sel[p] = 1;
        else if (w && m_frc[p]) m_frc[p] = 0;
        else if (!w && !m_frc[p]) m_frc[p] = 1;
        else if (!w && m_sel[p]) m_sel[p] = 0;
      end
      if (req && we && rdy) begin
        int nb;
        nb = wdata[24] + wdata[25] + wdata[26];
        if (nb <= 1) begin m_mode = int'(wdata[26:24]); m_err = 0; end
        else m_err = 1;
      end
      m_wait = req && we && full && !m_wait;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (running) begin
      logic [4:0] es, ef, ec, eu, ed;
      for (int p = 0; p < 5; p++) begin
        es[p] = m_sel[p];
        ef[p] = m_frc[p];
        // R5 safe levels: TMS 1, TCK 0, TDI 1, TDO 0, nTRST 1
        ec[p] = m_frc[p] ? (p == 0 || p == 2 || p == 4) : pad[p];
        eu[p] = m_sel[p] && (p == 0 || p == 2 || p == 4);
        ed[p] = m_sel[p] && (p == 1);
      end
      chk("R2/R4/R6 select", 32'(sel), 32'(es));
      chk("R4/R6 force", 32'(frc), 32'(ef));
      chk("R5 core input", 32'(core_in), 32'(ec));
      chk("R9 pull-up", 32'(pu), 32'(eu));
      chk("R9 pull-down", 32'(pd), 32'(ed));
      chk("R2/R10 read data", rdata, 32'(m_mode) << 24);
      chk("R7/R8 ready", 32'(ready), 32'(exp_ready()));
      chk("R3 error flag", 32'(err), 32'(m_err));
    end
  end

  always @(negedge clk) pad <= pad + 5'd7;

  task automatic xfer(bit wr, logic [31:0] d, bit f, output int waits, output logic [31:0] rd);
    @(negedge clk);
    req = 1; we = wr; wdata = d; full = f;
    #1; waits = 0;
    while (!ready) begin @(negedge clk); #1; waits++; end
    rd = rdata;
    @(posedge clk);
    @(negedge clk);
    req = 0; we = 0; full = 0; wdata = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int w;
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    #1;
    // R1
    chk("R1 reset select", 32'(sel), 32'h1f);
    chk("R1 reset force", 32'(frc), 32'h0);
    chk("R1 reset field", rdata, 32'h0);
    chk("R1 reset error", 32'(err), 32'h0);
    rst_n = 1;
    running = 1;
    idle(2);

    xfer(1, 32'h0100_0000, 0, w, rd);           // mode 001
    chk("R8 write wait, buffer free", 32'(w), 32'd0);
    idle(1);
    #1 chk("R4 force before select", {27'd0, sel, 1'b0} | 32'(frc), {27'd0, 5'h1f, 1'b0} | 32'h10);
    idle(3);
    chk("R2 mode 001 ownership", 32'(sel), 32'h0f);

    xfer(1, 32'h0200_0000, 1, w, rd);           // mode 010, full buffer
    chk("R8 write wait, buffer full", 32'(w), 32'd1);
    idle(4);
    chk("R2 mode 010 ownership", 32'(sel), 32'h03);

    xfer(1, 32'h0600_0000, 0, w, rd);           // illegal 110
    idle(2);
    chk("R3 illegal write keeps mode", rdata, 32'h0200_0000);
    chk("R3 illegal write raises flag", 32'(err), 32'h1);
    chk("R3 ownership unchanged", 32'(sel), 32'h03);

    xfer(0, 32'h0, 0, w, rd);
    chk("R7 read wait", 32'(w), 32'd0);
    chk("R7 read data", rd, 32'h0200_0000);

    xfer(1, 32'h84FF_00FF, 1, w, rd);           // mode 100 with junk
    idle(4);
    chk("R10 reserved bits ignored", rdata, 32'h0400_0000);
    chk("R2 mode 100 ownership", 32'(sel), 32'h00);
    chk("R9 no pulls released", 32'(pu | pd), 32'h0);

    xfer(1, 32'h0000_0000, 0, w, rd);           // back to full
    idle(1);
    #1 chk("R6 select before unforce", 32'(frc), 32'h1f);
    idle(3);
    chk("R6 full ownership restored", 32'(sel), 32'h1f);
    chk("R6 force cleared", 32'(frc), 32'h0);

    xfer(1, 32'h0500_0000, 1, w, rd);           // illegal 101
    idle(3);
    chk("R3 illegal from 000", 32'(sel), 32'h1f);
    xfer(1, 32'h0100_0000, 0, w, rd);
    idle(3);
    chk("R3 legal write clears flag", 32'(err), 32'h0);

    // back-to-back writes across a pending release
    xfer(1, 32'h0400_0000, 0, w, rd);
    xfer(1, 32'h0200_0000, 1, w, rd);
    idle(5);
    chk("R2/R6 settle after back-to-back", 32'(sel), 32'h03);

    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule